// File: doc/BRIEF.md
# Zigzag Scan and Run-Length Symbol Coder

This block sits between a coefficient quantizer and a variable-length code stage in an image compression pipeline. A square block of quantized transform coefficients is written into it in raster order, one coefficient per accepted beat. A component tag is taken with the first beat: luminance (Y), blue-difference chroma (Cb) or red-difference chroma (Cr). Once the block is complete, a sequencer walks the coefficients along the anti-diagonal zigzag path. The path starts at the top-left term and ends at the bottom-right one, so the low spatial frequencies come out first.

The sequencer produces a stream of symbol records. The first term of each block is the mean (DC) term, and it is sent as the change from the last DC value seen for the same component. The three components keep separate predictors, and a restart input clears all of them. The other terms (AC) are sent as a pair: the count of zeros skipped since the previous nonzero term, and the nonzero value itself. A count too large for the run field is broken up with sixteen-zero escape records. A tail of zeros is closed with a single end-of-block record. Both edges use a valid/ready handshake. The output record is held in a register that reloads in the same cycle it is consumed, so a free-flowing output handles one coefficient per clock.

Top module: `zz_rle_coder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` stays 1 until 64 coefficients have been accepted, and stays 0 from the cycle after the 64th accepted beat until the scan of that block ends. Beat i holds raster element row*8+col, with i = row*8+col. `in_comp` is taken from the first beat of each block.
- R2: Records come out in zigzag order. The order starts (0,0), (0,1), (1,0), (2,0), (1,1), (0,2), … as (row,col). Each anti-diagonal is walked alternately up and down, and the order ends at (7,7).
- R3: Each block's first record is a DC record: kind 0, run 0, value = first coefficient minus that component's predictor, modulo 2^12. The predictor then takes the first coefficient.
- R4: Tag codes are Y=0, Cb=1, Cr=2. Each code has its own predictor, and a block of one component leaves the other two predictors unchanged.
- R5: A one-cycle `restart` pulse clears all three predictors to 0, so the next DC value of each component is sent unchanged.
- R6: An AC record is kind 1. Its run is the number of zero terms since the previous emitted nonzero term (or since DC), less 16 for each escape already sent. Its value is the nonzero coefficient, which is never 0.
- R7: When 16 or more zeros precede a nonzero term, one escape record (kind 2, run 15, value 0) is sent for each 16 zeros before that term's AC record.
- R8: If the last zigzag term (7,7) is zero, exactly one end-of-block record (kind 3, run 0, value 0) closes the block, and no escape is sent for the trailing zeros. If that term is nonzero, its AC record closes the block and no end-of-block record follows.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_kind`, `out_run` and `out_value` keep their values.
- R10: With `out_ready` held 1, `in_ready` is 0 for exactly 64 plus (number of escape records) cycles after the accept edge of a block's last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Clears all DC predictors |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block loader can take a coefficient |
| in_coef | input | 12 | Quantized coefficient, two's complement, raster order |
| in_comp | input | 2 | Component tag, read on the first beat of a block |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream takes the record |
| out_kind | output | 2 | 0 DC, 1 AC, 2 sixteen-zero escape, 3 end of block |
| out_run | output | 4 | Zero run count |
| out_value | output | 12 | DC difference or AC value, two's complement |

## Verification
The bench aims at the run boundaries. These are a run of exactly 16 zeros, a run of 40 zeros, a block whose only AC term is the last one, and a block with no AC terms at all. A coder off by one in its escape threshold would send a record with run 0 too early or a run of 16 that wraps to 0. A coder that mishandles the last term would drop or duplicate the end-of-block record. The DC path is checked across alternating components and across a restart: a shared predictor, or one that restart misses, yields wrong differences. Random blocks under random back-pressure check that a stalled record is never changed or lost, and free-flowing blocks check the one-term-per-cycle scan time.

// File: rtl/zz_rle_pkg.sv
package zz_rle_pkg;

   typedef enum logic [1:0] {
      KIND_DC  = 2'd0,
      KIND_AC  = 2'd1,
      KIND_ZRL = 2'd2,
      KIND_EOB = 2'd3
   } rec_kind_e;

   // Raster address (row*side+col) of the idx-th element along the
   // zigzag path: even diagonals run bottom-left to top-right.
   function automatic int zz_raster(input int idx, input int side);
      int n;
      int r;
      int c;
      n = 0;
      for (int s = 0; s <= 2 * side - 2; s++) begin
         for (int t = 0; t < side; t++) begin
            if (s % 2 == 0)
               r = ((s < side) ? s : side - 1) - t;
            else
               r = ((s < side) ? 0 : s - side + 1) + t;
            c = s - r;
            if (r >= 0 && r < side && c >= 0 && c < side) begin
               if (n == idx) return r * side + c;
               n++;
            end
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/zz_coef_store.sv
module zz_coef_store #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 12,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/zz_order_rom.sv
module zz_order_rom #(
   parameter int SIDE = 8,
   localparam int N   = SIDE * SIDE,
   localparam int AW  = $clog2(N)
) (
   input  logic [AW-1:0] pos,
   output logic [AW-1:0] raster
);
   logic [AW-1:0] tbl [N];

   for (genvar g = 0; g < N; g++) begin : g_entry
      localparam int RAS = zz_rle_pkg::zz_raster(g, SIDE);
      assign tbl[g] = AW'(RAS);
   end

   assign raster = tbl[pos];
endmodule

// File: rtl/zz_dc_pred.sv
module zz_dc_pred #(
   parameter int COEF_W   = 12,
   parameter int NUM_COMP = 3,
   localparam int CW      = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              upd,
   input  logic [CW-1:0]     comp,
   input  logic [COEF_W-1:0] new_dc,
   output logic [COEF_W-1:0] pred
);
   logic [COEF_W-1:0] pred_q [NUM_COMP];
   logic [CW-1:0]     sel;

   assign sel = (int'(comp) < NUM_COMP) ? comp : '0;

   for (genvar g = 0; g < NUM_COMP; g++) begin : g_comp
      always_ff @(posedge clk) begin
         if (!rst_n || clear)
            pred_q[g] <= '0;
         else if (upd && int'(sel) == g)
            pred_q[g] <= new_dc;
      end
   end

   assign pred = pred_q[sel];
endmodule

// File: rtl/zz_scan_ctrl.sv
module zz_scan_ctrl
   import zz_rle_pkg::*;
#(
   parameter int N      = 64,
   parameter int COEF_W = 12,
   parameter int RUN_W  = 4,
   localparam int AW    = $clog2(N),
   localparam int ZSPAN = 2 ** RUN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COEF_W-1:0] coef,
   input  logic [COEF_W-1:0] dc_pred,
   output logic [AW-1:0]     pos,
   output logic              busy,
   output logic              dc_upd,
   input  logic              out_ready,
   output logic              out_valid,
   output rec_kind_e         out_kind,
   output logic [RUN_W-1:0]  out_run,
   output logic [COEF_W-1:0] out_value
);
   logic [AW-1:0] zrun;
   logic          is_dc, is_last, is_zero;
   logic          slot_free, emit_req, need_zrl, step, advance;
   rec_kind_e     nxt_kind;
   logic [RUN_W-1:0]  nxt_run;
   logic [COEF_W-1:0] nxt_value;

   assign is_dc     = (pos == '0);
   assign is_last   = (pos == AW'(N - 1));
   assign is_zero   = (coef == '0);
   assign slot_free = !out_valid || out_ready;
   assign need_zrl  = busy && !is_dc && !is_zero && (zrun >= AW'(ZSPAN));
   assign emit_req  = busy && (is_dc || !is_zero || is_last);
   assign step      = busy && (!emit_req || slot_free);
   assign advance   = step && !need_zrl;
   assign dc_upd    = step && is_dc;

   always_comb begin
      nxt_kind  = KIND_EOB;
      nxt_run   = '0;
      nxt_value = '0;
      if (is_dc) begin
         nxt_kind  = KIND_DC;
         nxt_value = coef - dc_pred;
      end else if (need_zrl) begin
         nxt_kind  = KIND_ZRL;
         nxt_run   = '1;
      end else if (!is_zero) begin
         nxt_kind  = KIND_AC;
         nxt_run   = RUN_W'(zrun);
         nxt_value = coef;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
         zrun <= '0;
      end else if (start) begin
         busy <= 1'b1;
         pos  <= '0;
         zrun <= '0;
      end else if (step) begin
         if (need_zrl)
            zrun <= zrun - AW'(ZSPAN);
         else if (!is_dc && is_zero)
            zrun <= zrun + 1'b1;
         else
            zrun <= '0;
         if (advance) begin
            if (is_last) busy <= 1'b0;
            else         pos  <= pos + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= KIND_DC;
         out_run   <= '0;
         out_value <= '0;
      end else if (emit_req && step) begin
         out_valid <= 1'b1;
         out_kind  <= nxt_kind;
         out_run   <= nxt_run;
         out_value <= nxt_value;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/zz_rle_coder.sv
module zz_rle_coder
   import zz_rle_pkg::*;
#(
   parameter int SIDE     = 8,
   parameter int COEF_W   = 12,
   parameter int RUN_W    = 4,
   parameter int NUM_COMP = 3,
   localparam int N       = SIDE * SIDE,
   localparam int AW      = $clog2(N),
   localparam int CW      = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [COEF_W-1:0] in_coef,
   input  logic [CW-1:0]     in_comp,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [RUN_W-1:0]  out_run,
   output logic [COEF_W-1:0] out_value
);
   if (SIDE < 2) begin : g_bad_side
      $error("zz_rle_coder: SIDE must be at least 2");
   end
   if (COEF_W < 2) begin : g_bad_coef
      $error("zz_rle_coder: COEF_W must be at least 2");
   end
   if (RUN_W < 1 || (2 ** RUN_W) >= N) begin : g_bad_run
      $error("zz_rle_coder: run field must be narrower than the block");
   end
   if (NUM_COMP < 1) begin : g_bad_comp
      $error("zz_rle_coder: NUM_COMP must be at least 1");
   end

   logic [AW-1:0]     fill;
   logic [CW-1:0]     comp_q;
   logic              accept, start, busy, dc_upd;
   logic [AW-1:0]     pos, raddr;
   logic [COEF_W-1:0] rdata, dc_pred;
   rec_kind_e         kind_q;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;
   assign start    = accept && (fill == AW'(N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill   <= '0;
         comp_q <= '0;
      end else if (accept) begin
         fill <= start ? '0 : fill + 1'b1;
         if (fill == '0) comp_q <= in_comp;
      end
   end

   zz_coef_store #(.DEPTH(N), .DATA_W(COEF_W)) u_store (
      .clk   (clk),
      .we    (accept),
      .waddr (fill),
      .wdata (in_coef),
      .raddr (raddr),
      .rdata (rdata)
   );

   zz_order_rom #(.SIDE(SIDE)) u_order (
      .pos    (pos),
      .raster (raddr)
   );

   zz_dc_pred #(.COEF_W(COEF_W), .NUM_COMP(NUM_COMP)) u_pred (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (restart),
      .upd    (dc_upd),
      .comp   (comp_q),
      .new_dc (rdata),
      .pred   (dc_pred)
   );

   zz_scan_ctrl #(.N(N), .COEF_W(COEF_W), .RUN_W(RUN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .coef      (rdata),
      .dc_pred   (dc_pred),
      .pos       (pos),
      .busy      (busy),
      .dc_upd    (dc_upd),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_kind  (kind_q),
      .out_run   (out_run),
      .out_value (out_value)
   );

   assign out_kind = kind_q;
endmodule

// File: rtl/zz_rle_coder_chk.sv
module zz_rle_coder_chk #(
   parameter int COEF_W = 12,
   parameter int RUN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_kind,
   input logic [RUN_W-1:0]  out_run,
   input logic [COEF_W-1:0] out_value
);
   // R9: a stalled record is held unchanged
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_kind)
                                 && $stable(out_run) && $stable(out_value));

   // R3: DC records carry no run
   assert_dc_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 2'd0 |-> out_run == '0);

   // R6: AC records never carry a zero value
   assert_ac_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 2'd1 |-> out_value != '0);

   // R7: escape records have full run and zero value
   assert_zrl_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 2'd2 |-> out_run == '1 && out_value == '0);

   // R8: end-of-block records are all zero
   assert_eob_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 2'd3 |-> out_run == '0 && out_value == '0);
endmodule

bind zz_rle_coder zz_rle_coder_chk #(.COEF_W(COEF_W), .RUN_W(RUN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_kind  (out_kind),
   .out_run   (out_run),
   .out_value (out_value)
);

// File: tb/test_zz_rle_coder.sv
`timescale 1ns/1ps
module test_zz_rle_coder;
   logic        clk = 1'b0;
   logic        rst_n, restart, in_valid, in_ready, out_valid, out_ready;
   logic [11:0] in_coef, out_value;
   logic [1:0]  in_comp, out_kind;
   logic [3:0]  out_run;

   always #10 clk = ~clk;   // 50 MHz

   zz_rle_coder i_zz_rle_coder (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef), .in_comp(in_comp),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_run(out_run), .out_value(out_value)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int zz [64];
   logic [11:0] blk [64];
   logic [11:0] mpred [3];
   logic [17:0] exp_q [$];
   string       tag_q [$];
   string       dc_tag = "R3 R4";
   bit          stall_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // back-pressure driven on the rising edge so the negedge monitor sees a stable value
   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= stall_mode ? (lfsr[0] & ~lfsr[5]) : 1'b1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish (actual cycles %0d, expected fewer)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // scoreboard monitor
   bit          held = 1'b0;
   logic [17:0] held_rec;
   always @(negedge clk) begin
      if (rst_n) begin
         if (held && out_valid) begin
            n_checks++;   // R9
            if ({out_kind, out_run, out_value} !== held_rec) begin
               n_fail++;
               $display("FAIL R9 stalled record changed: actual %h expected %h",
                        {out_kind, out_run, out_value}, held_rec);
            end
         end
         held     = out_valid && !out_ready;
         held_rec = {out_kind, out_run, out_value};
         if (out_valid && out_ready) begin
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R2 unexpected record: actual %h expected none",
                        {out_kind, out_run, out_value});
            end else begin
               logic [17:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if ({out_kind, out_run, out_value} !== e) begin
                  n_fail++;
                  $display("FAIL R2 %s record mismatch: actual kind %0d run %0d value %h, expected kind %0d run %0d value %h",
                           t, out_kind, out_run, out_value, e[17:16], e[15:12], e[11:0]);
               end
            end
         end
      end
   end

   task automatic clear_blk(input logic [11:0] dc);
      for (int i = 0; i < 64; i++) blk[i] = '0;
      blk[0] = dc;
   endtask

   task automatic set_zz(input int p, input logic [11:0] v);
      blk[zz[p]] = v;
   endtask

   task automatic push(input logic [1:0] k, input logic [3:0] r, input logic [11:0] v,
                       input string t);
      exp_q.push_back({k, r, v});
      tag_q.push_back(t);
   endtask

   task automatic send_block(input int comp, input bit timed);
      int run;
      int nzrl;
      int cnt;
      logic [11:0] v;
      push(2'd0, 4'd0, blk[0] - mpred[comp], dc_tag);
      mpred[comp] = blk[0];
      run = 0;
      nzrl = 0;
      for (int p = 1; p < 64; p++) begin
         v = blk[zz[p]];
         if (v == '0) run++;
         else begin
            while (run > 15) begin
               push(2'd2, 4'd15, '0, "R7");
               run -= 16;
               nzrl++;
            end
            push(2'd1, 4'(run), v, "R6");
            run = 0;
         end
      end
      if (blk[zz[63]] == '0) push(2'd3, 4'd0, '0, "R8");
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_coef  = blk[i];
         in_comp  = (i == 0) ? 2'(comp) : 2'(2 - comp);  // only beat 0 counts (R1)
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (timed) begin
         cnt = 0;
         while (!in_ready) begin
            cnt++;
            @(negedge clk);
         end
         n_checks++;
         if (cnt != 64 + nzrl) begin
            n_fail++;
            $display("FAIL R10 R1 busy cycles: actual %0d expected %0d", cnt, 64 + nzrl);
         end
      end
   endtask

   initial begin
      int r, c;
      r = 0; c = 0;
      for (int i = 0; i < 64; i++) begin
         zz[i] = r * 8 + c;
         if ((r + c) % 2 == 0) begin
            if (c == 7) r++;
            else if (r == 0) c++;
            else begin r--; c++; end
         end else begin
            if (r == 7) c++;
            else if (c == 0) r++;
            else begin r++; c--; end
         end
      end
      for (int i = 0; i < 3; i++) mpred[i] = '0;
      rst_n = 1'b0; restart = 1'b0; in_valid = 1'b0; in_coef = '0; in_comp = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset state: actual in_ready %b out_valid %b expected 1 0",
                  in_ready, out_valid);
      end

      // R2 R6 R8: short run-lengths then a zero tail
      clear_blk(12'd50);
      set_zz(1, -12'sd3); set_zz(2, 12'd5); set_zz(5, 12'd1); set_zz(9, 12'd7);
      send_block(0, 1);
      // R3: same component, DC falls by 20
      clear_blk(12'd30); set_zz(3, 12'd4);
      send_block(0, 1);
      // R4: Cb has its own predictor
      clear_blk(-12'sd100); set_zz(17, 12'd9);
      send_block(1, 1);
      // R7: exactly 16 zeros, then 40 zeros; R8: last term nonzero, no EOB
      clear_blk(12'd30);
      set_zz(17, 12'd2); set_zz(58, -12'sd6); set_zz(63, 12'd1);
      send_block(0, 1);
      // R8: no AC terms at all
      clear_blk(12'd5);
      send_block(2, 1);
      // R7 R8: only the last term set, 62 zeros before it
      clear_blk(-12'sd90); set_zz(63, 12'd1);
      send_block(1, 1);
      // R5: restart clears every predictor
      @(negedge clk); restart = 1'b1;
      @(negedge clk); restart = 1'b0;
      for (int i = 0; i < 3; i++) mpred[i] = '0;
      dc_tag = "R5";
      clear_blk(12'd7); set_zz(4, 12'd3);
      send_block(0, 1);
      clear_blk(-12'sd4);
      send_block(1, 1);
      clear_blk(12'd2047); set_zz(62, 12'd8);
      send_block(2, 1);
      dc_tag = "R3 R4";
      // R9: random blocks under random back-pressure
      stall_mode = 1'b1;
      for (int b = 0; b < 14; b++) begin
         clear_blk(12'($urandom_range(0, 4095)));
         for (int p = 1; p < 64; p++)
            if ($urandom_range(0, 7) == 0)
               set_zz(p, 12'($urandom_range(1, 300)) - 12'd150);
         for (int p = 1; p < 64; p++)
            if (blk[zz[p]] == '0 && $urandom_range(0, 1) == 0) blk[zz[p]] = '0;
         send_block(int'($urandom_range(0, 2)), 0);
      end
      stall_mode = 1'b0;
      while (exp_q.size() != 0 || !in_ready || out_valid) @(negedge clk);
      repeat (5) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R2 records missing: actual %0d left expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule